// File: doc/BRIEF.md
# Interrupt priority threshold arbiter

This block picks the one interrupt source to offer to a single hart. Each source has a pending bit, an enable bit and a 3-bit priority. A hart-wide 2-bit threshold applies to all of them. Of the sources that are both pending and enabled, the block keeps only those whose priority is strictly above the threshold. From those it chooses the highest priority, and on a tie the lowest source number. The winner is registered on every clock. The registered value is what a claim read returns, and the external-interrupt request to the core is high whenever that value is nonzero.

The register file and the per-source gateways sit outside this block. They feed it the pending, enable, priority and threshold values. They also pulse `claim_rd_i` when software reads the claim location. On that pulse the block returns its held winner to 0 for one cycle, then arbitrates again on whatever inputs it sees next. Source number 0 is reserved to mean "nothing", so bit 0 of the vectors never takes part.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `win_id_o` is 0 and `irq_o` is 0.
- R2: A source takes part only when both its `pend_i` bit and its `en_i` bit are 1.
- R3: A source is offered only when its priority, read as an unsigned 3-bit number, is strictly greater than `thr_i` zero-extended to 3 bits. A priority equal to the threshold never wins, and priority 0 never wins.
- R4: Among qualifying sources, the one with the highest priority wins.
- R5: Among qualifying sources of equal highest priority, the lowest source number wins.
- R6: When no source qualifies, `win_id_o` is 0 and `irq_o` is 0.
- R7: `irq_o` is 1 exactly when `win_id_o` is nonzero.
- R8: In the cycle after a cycle in which `claim_rd_i` is 1, `win_id_o` is 0. One cycle later it shows the arbitration of the inputs then present.
- R9: `win_id_o` changes only on a clock edge. It shows the result for the inputs sampled at that edge, so an input change becomes visible one edge later and not before.
- R10: Source 0 (bit 0 of `pend_i` and `en_i`, bits [2:0] of `prio_i`) is ignored, whatever its values. Source i's priority occupies bits [3i+2:3i] of `prio_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NSRC | Pending bit for each source |
| en_i | input | NSRC | Enable bit for each source |
| prio_i | input | NSRC*PRIO_W | Packed priorities, source i at bits [PRIO_W*i +: PRIO_W] |
| thr_i | input | THR_W | Priority threshold of the hart |
| claim_rd_i | input | 1 | Pulse marking a claim read of the current winner |
| win_id_o | output | $clog2(NSRC) | Registered winning source number, 0 for none |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
Every result comes one clock edge after its inputs. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, once the single rising edge between them has loaded the register. For R9 it also reads the outputs a few nanoseconds after driving and before that rising edge, and expects the old value there. The claim sequence is sampled on two falling edges in a row: the first must show 0, the second the recomputed winner.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int THR_W  = 2,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [THR_W-1:0]       thr_i,
  input  logic                   claim_rd_i,
  output logic [ID_W-1:0]        win_id_o,
  output logic                   irq_o
);

  logic [PRIO_W-1:0] best;
  logic [ID_W-1:0]   cand;

  always_comb begin
    best = PRIO_W'(thr_i);
    cand = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        best = prio_i[i*PRIO_W +: PRIO_W];
        cand = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_id_o <= '0;
      irq_o    <= 1'b0;
    end else if (claim_rd_i) begin
      win_id_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      win_id_o <= cand;
      irq_o    <= (cand != '0);
    end
  end

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int THR_W  = 2,
  localparam int ID_W  = $clog2(NSRC)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSRC-1:0]        pend_i,
  input logic [NSRC-1:0]        en_i,
  input logic [NSRC*PRIO_W-1:0] prio_i,
  input logic [THR_W-1:0]       thr_i,
  input logic                   claim_rd_i,
  input logic [ID_W-1:0]        win_id_o,
  input logic                   irq_o
);

  logic [NSRC-1:0]        pe_d;
  logic [NSRC*PRIO_W-1:0] prio_d;
  logic [THR_W-1:0]       thr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_d   <= '0;
      prio_d <= '0;
      thr_d  <= '0;
    end else begin
      pe_d   <= pend_i & en_i;
      prio_d <= prio_i;
      thr_d  <= thr_i;
    end
  end

  p_irq_tracks_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (win_id_o != '0));

  p_claim_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd_i |=> (win_id_o == '0));

  p_winner_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id_o != '0) |-> pe_d[win_id_o]);

  p_above_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id_o != '0) |-> (prio_d[win_id_o*PRIO_W +: PRIO_W] > PRIO_W'(thr_d)));

  p_idle_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_d[NSRC-1:1] == '0) |-> (win_id_o == '0));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .THR_W(THR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
  .thr_i(thr_i), .claim_rd_i(claim_rd_i), .win_id_o(win_id_o), .irq_o(irq_o)
);

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
  localparam int NSRC = 32;
  localparam int PW   = 3;
  localparam int IDW  = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]    pend = '0;
  logic [NSRC-1:0]    en = '0;
  logic [NSRC*PW-1:0] prio = '0;
  logic [1:0]         thr = '0;
  logic               claim = 1'b0;
  logic [IDW-1:0]     win_id;
  logic               irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_prio_arbiter #(.NSRC(NSRC), .PRIO_W(PW), .THR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .thr_i(thr), .claim_rd_i(claim), .win_id_o(win_id), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    pend = '0; en = '0; prio = '0; thr = '0; claim = 1'b0;
  endtask

  task automatic src(int id, int p);
    pend[id] = 1'b1;
    en[id] = 1'b1;
    prio[id*PW +: PW] = PW'(p);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 id in reset", int'(win_id), 0);
    chk("R1 irq in reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 id after reset", int'(win_id), 0);
  endtask

  task automatic t_gating();
    @(negedge clk); clear_all(); src(5, 3);
    settle();
    chk("R2 single source id", int'(win_id), 5);
    chk("R7 irq high with winner", int'(irq), 1);
    en[5] = 1'b0;
    settle();
    chk("R2 disabled source", int'(win_id), 0);
    en[5] = 1'b1; pend[5] = 1'b0;
    settle();
    chk("R2 not pending source", int'(win_id), 0);
    chk("R7 irq low without winner", int'(irq), 0);
  endtask

  task automatic t_threshold();
    @(negedge clk); clear_all(); thr = 2'd2; src(7, 2);
    settle();
    chk("R3 priority equal to threshold", int'(win_id), 0);
    prio[7*PW +: PW] = 3'd3;
    settle();
    chk("R3 priority above threshold", int'(win_id), 7);
    thr = 2'd0; prio[7*PW +: PW] = 3'd0;
    settle();
    chk("R3 priority zero", int'(win_id), 0);
  endtask

  task automatic t_highest();
    @(negedge clk); clear_all(); src(3, 2); src(20, 6); src(31, 5);
    settle();
    chk("R4 highest priority", int'(win_id), 20);
  endtask

  task automatic t_tie();
    @(negedge clk); clear_all(); src(9, 5); src(4, 5); src(30, 5); src(2, 1);
    settle();
    chk("R5 tie lowest id", int'(win_id), 4);
  endtask

  task automatic t_none();
    @(negedge clk); clear_all(); thr = 2'd3; src(11, 3); src(12, 1);
    settle();
    chk("R6 none qualify id", int'(win_id), 0);
    chk("R6 none qualify irq", int'(irq), 0);
  endtask

  task automatic t_claim();
    @(negedge clk); clear_all(); src(12, 4);
    settle();
    chk("R8 before claim", int'(win_id), 12);
    claim = 1'b1;
    @(negedge clk);
    claim = 1'b0;
    chk("R8 id cleared after claim", int'(win_id), 0);
    chk("R8 irq cleared after claim", int'(irq), 0);
    pend[12] = 1'b0; src(13, 2);
    settle();
    chk("R8 recomputed after claim", int'(win_id), 13);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_all(); src(6, 4);
    settle();
    src(25, 7);
    #3;
    chk("R9 no change before edge", int'(win_id), 6);
    settle();
    chk("R9 change after edge", int'(win_id), 25);
  endtask

  task automatic t_src0();
    @(negedge clk); clear_all(); src(0, 7);
    settle();
    chk("R10 source 0 ignored", int'(win_id), 0);
    src(1, 1);
    settle();
    chk("R10 source 1 wins over source 0", int'(win_id), 1);
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_gating();
    t_threshold();
    t_highest();
    t_tie();
    t_none();
    t_claim();
    t_latency();
    t_src0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule